// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation Checker

This block receives a ternary line signal that an external slicer has already split into two unipolar rails, one for positive marks and one for negative marks. It rebuilds the binary bit stream under one of four line codes: plain alternate mark inversion, or one of three zero-substitution codes (an 8-zero code, a 6-zero code, and a 4-zero code with two substitution forms). Every substitution sequence it recognises on the line is turned back into zeros. The decoder takes one line symbol per clock and returns one data bit per clock after a latency that depends on the code, with no stall.

Alongside the data it raises an error flag that lines up with the decoded bit. The flag reports a mark that repeats the polarity of the previous pulse without being part of a recognised substitution, a run of line zeros longer than the selected code allows, and a symbol with both rails high. Recognition is judged against the polarity of the last pulse seen, so the two rails can be wired either way round. Clock recovery and slicing are done elsewhere; the code select is expected to stay fixed while data flows.

Top module: `bpl_decoder`

## Requirements
- R1: The line symbol sampled on rising edge k appears on `nrz_out` and `err_out` after edge k+L, where L is 1 for the mark-inversion code, 8 for the 8-zero code, 6 for the 6-zero code and 4 for the 4-zero code.
- R2: `code_sel` selects the line code: 2'b00 mark inversion, 2'b01 8-zero substitution, 2'b10 6-zero substitution, 2'b11 4-zero substitution.
- R3: In mark-inversion mode, a symbol with exactly one rail high decodes as 1 and a symbol with both rails low decodes as 0; marks of alternating polarity raise no error.
- R4: In 8-zero mode, with P the polarity of the last pulse, the symbols 0,0,0,P,-P,0,-P,P decode as eight zeros with no error.
- R5: In 6-zero mode, with P the polarity of the last pulse, the symbols 0,P,-P,0,-P,P decode as six zeros with no error.
- R6: In 4-zero mode, with P the polarity of the last pulse, both 0,0,0,P and -P,0,0,-P decode as four zeros with no error.
- R7: A single-rail mark with the same polarity as the previous pulse that is not part of a recognised substitution decodes as 1 and raises `err_out` for that bit only.
- R8: `err_out` is raised for exactly one bit, the line zero that makes the run one longer than the limit: 15 in mark-inversion mode, 8 in 8-zero mode, 6 in 6-zero mode, 4 in 4-zero mode.
- R9: A symbol with both rails high decodes as 1, raises `err_out` for that bit, and leaves the remembered pulse polarity unchanged.
- R10: Exchanging `rail_p` and `rail_n` leaves the decoded data and the error flag unchanged.
- R11: While `rst_n` is low both outputs are 0; reset clears the remembered polarity, so the first mark after reset is never a violation and no substitution is recognised before the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock; rails sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sel | input | 2 | Line code select (R2 encoding) |
| rail_p | input | 1 | Positive-mark rail |
| rail_n | input | 1 | Negative-mark rail |
| nrz_out | output | 1 | Decoded data bit |
| err_out | output | 1 | Error flag, aligned with the decoded bit |

## Verification
On every cycle the assertions check that a line zero never decodes as a one, that a mark always decodes as a one in mark-inversion mode, that a both-rails symbol yields a one with the error flag after the mode's latency, that an over-long zero run raises the flag, and that reset holds both outputs low. Whether substitution sequences are removed with the right polarity in every mode, whether rail exchange is transparent, and whether the flag stays low on clean encoded traffic can only be shown by the bench, which encodes a sweep of every byte value in each mode and compares the decoded stream bit by bit, then adds hand-built violation, zero-run and reset cases.

// File: rtl/bpl_pkg.sv
`timescale 1ns/1ps
package bpl_pkg;
  typedef enum logic [1:0] {
    LC_AMI = 2'b00,
    LC_B8  = 2'b01,
    LC_B6  = 2'b10,
    LC_HDB = 2'b11
  } lcode_e;

  // {positive rail, negative rail}
  typedef logic [1:0] rail_t;

  // substitution element codes: 0 = zero, 1 = same as last pulse, 2 = opposite
  // element j (oldest first) sits at bits [2j+1:2j]
  localparam logic [15:0] SUB_B8  = 16'h6240;  // Z Z Z S O Z O S
  localparam logic [15:0] SUB_B6  = 16'h0624;  // Z S O Z O S
  localparam logic [15:0] SUB_H4A = 16'h0040;  // Z Z Z S
  localparam logic [15:0] SUB_H4B = 16'h0082;  // O Z Z O

  function automatic logic [3:0] sub_len(input logic [1:0] m);
    case (lcode_e'(m))
      LC_AMI:  return 4'd1;
      LC_B8:   return 4'd8;
      LC_B6:   return 4'd6;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/bpl_window.sv
`timescale 1ns/1ps
module bpl_window
  import bpl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rail_t                 sym_in,
  input  logic                  det,
  input  logic [3:0]            plen,
  output logic [DEPTH-1:0][1:0] win,
  output logic [DEPTH-1:0]      msk,
  output logic [DEPTH-1:0]      vld
);
  logic [DEPTH-1:0] msk_n;

  assign msk_n[0] = 1'b0;
  for (genvar i = 1; i < DEPTH; i++) begin : g_msk
    // a detected substitution covers window slots 0..plen-1; they move up one
    assign msk_n[i] = msk[i-1] | (det && ((i - 1) < int'(plen)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      msk <= '0;
      vld <= '0;
    end else begin
      win <= {win[DEPTH-2:0], sym_in};
      vld <= {vld[DEPTH-2:0], 1'b1};
      msk <= msk_n;
    end
  end
endmodule

// File: rtl/bpl_matcher.sv
`timescale 1ns/1ps
module bpl_matcher
  import bpl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0][1:0] win,
  input  logic [DEPTH-1:0]      msk,
  input  rail_t                 pol,
  input  logic [1:0]            code_sel,
  input  logic                  tap_vld,
  output logic                  det
);
  // pattern oldest element sits at slot plen-1 (the tap), newest at slot 0
  function automatic logic fit(input logic [DEPTH-1:0][1:0] w,
                               input logic [DEPTH-1:0] m,
                               input rail_t p,
                               input logic [15:0] codes,
                               input int plen);
    rail_t want;
    int    j;
    fit = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < plen) begin
        j = plen - 1 - i;
        case (codes[2*j +: 2])
          2'd1:    want = p;
          2'd2:    want = {p[0], p[1]};
          default: want = 2'b00;
        endcase
        if (w[i] != want || m[i]) fit = 1'b0;
      end
    end
  endfunction

  logic hit;
  always_comb begin
    case (lcode_e'(code_sel))
      LC_B8:   hit = fit(win, msk, pol, SUB_B8, 8);
      LC_B6:   hit = fit(win, msk, pol, SUB_B6, 6);
      LC_HDB:  hit = fit(win, msk, pol, SUB_H4A, 4) | fit(win, msk, pol, SUB_H4B, 4);
      default: hit = 1'b0;
    endcase
  end

  // a pulse must have been seen, and the whole pattern must be real data
  assign det = hit && tap_vld && (^pol);
endmodule

// File: rtl/bpl_monitor.sv
`timescale 1ns/1ps
module bpl_monitor
  import bpl_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_vld,
  input  rail_t            tap,
  input  logic             tap_sub,
  input  logic [CNT_W-1:0] zlim,
  output logic             nrz,
  output logic             err,
  output rail_t            pol
);
  logic [CNT_W-1:0] zcnt;
  logic is_zero, is_both, is_mark, viol, over;

  assign is_zero = (tap == 2'b00);
  assign is_both = (tap == 2'b11);
  assign is_mark = ^tap;
  assign viol    = is_mark && !tap_sub && (tap == pol);
  assign over    = is_zero && (zcnt == zlim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrz  <= 1'b0;
      err  <= 1'b0;
      pol  <= 2'b00;
      zcnt <= '0;
    end else if (tap_vld) begin
      nrz <= (is_mark && !tap_sub) || is_both;
      err <= viol || over || is_both;
      if (is_mark) pol <= tap;
      if (!is_zero)          zcnt <= '0;
      else if (zcnt <= zlim) zcnt <= zcnt + 1'b1;
    end else begin
      nrz <= 1'b0;
      err <= 1'b0;
    end
  end
endmodule

// File: rtl/bpl_decoder.sv
`timescale 1ns/1ps
module bpl_decoder
  import bpl_pkg::*;
#(
  parameter int WIN_DEPTH = 8,
  parameter int ZMAX_AMI  = 15,
  parameter int ZMAX_B8   = 8,
  parameter int ZMAX_B6   = 6,
  parameter int ZMAX_HDB  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_sel,
  input  logic       rail_p,
  input  logic       rail_n,
  output logic       nrz_out,
  output logic       err_out
);
  localparam int ZA    = (ZMAX_AMI > ZMAX_B8) ? ZMAX_AMI : ZMAX_B8;
  localparam int ZB    = (ZMAX_B6 > ZMAX_HDB) ? ZMAX_B6 : ZMAX_HDB;
  localparam int ZTOP  = (ZA > ZB) ? ZA : ZB;
  localparam int CNT_W = $clog2(ZTOP + 2);
  localparam int IW    = $clog2(WIN_DEPTH);

  logic [WIN_DEPTH-1:0][1:0] win;
  logic [WIN_DEPTH-1:0]      msk, vld;
  logic [3:0]                plen;
  logic [IW-1:0]             tix;
  logic                      det, tap_vld;
  rail_t                     pol;
  logic [CNT_W-1:0]          zlim;

  assign plen    = sub_len(code_sel);
  assign tix     = IW'(plen - 4'd1);
  assign tap_vld = vld[tix];

  always_comb begin
    case (lcode_e'(code_sel))
      LC_AMI:  zlim = CNT_W'(ZMAX_AMI);
      LC_B8:   zlim = CNT_W'(ZMAX_B8);
      LC_B6:   zlim = CNT_W'(ZMAX_B6);
      default: zlim = CNT_W'(ZMAX_HDB);
    endcase
  end

  bpl_window #(.DEPTH(WIN_DEPTH)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_in ({rail_p, rail_n}),
    .det    (det),
    .plen   (plen),
    .win    (win),
    .msk    (msk),
    .vld    (vld)
  );

  bpl_matcher #(.DEPTH(WIN_DEPTH)) u_match (
    .win      (win),
    .msk      (msk),
    .pol      (pol),
    .code_sel (code_sel),
    .tap_vld  (tap_vld),
    .det      (det)
  );

  bpl_monitor #(.CNT_W(CNT_W)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .tap_vld (tap_vld),
    .tap     (win[tix]),
    .tap_sub (msk[tix] | det),
    .zlim    (zlim),
    .nrz     (nrz_out),
    .err     (err_out),
    .pol     (pol)
  );
endmodule

// File: rtl/bpl_decoder_chk.sv
`timescale 1ns/1ps
module bpl_decoder_chk #(
  parameter int ZMAX_AMI = 15,
  parameter int ZMAX_B8  = 8,
  parameter int ZMAX_B6  = 6,
  parameter int ZMAX_HDB = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] code_sel,
  input logic       rail_p,
  input logic       rail_n,
  input logic       nrz_out,
  input logic       err_out
);
  logic [3:0] lat, settle;
  logic [1:0] code_q;
  logic [8:0] h_both, h_zero, h_mark, h_over;
  logic [4:0] run, lim;
  logic       in_zero, in_over;

  always_comb begin
    case (code_sel)
      2'b00:   begin lat = 4'd1; lim = 5'(ZMAX_AMI); end
      2'b01:   begin lat = 4'd8; lim = 5'(ZMAX_B8);  end
      2'b10:   begin lat = 4'd6; lim = 5'(ZMAX_B6);  end
      default: begin lat = 4'd4; lim = 5'(ZMAX_HDB); end
    endcase
  end

  assign in_zero = !rail_p && !rail_n;
  assign in_over = in_zero && (run == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= '0;
      code_q <= '0;
      run    <= '0;
      h_both <= '0;
      h_zero <= '0;
      h_mark <= '0;
      h_over <= '0;
    end else begin
      code_q <= code_sel;
      if (code_sel != code_q) settle <= '0;
      else if (settle != 4'd15) settle <= settle + 4'd1;
      if (!in_zero) run <= '0;
      else if (run <= lim) run <= run + 5'd1;
      h_both <= {h_both[7:0], rail_p && rail_n};
      h_zero <= {h_zero[7:0], in_zero};
      h_mark <= {h_mark[7:0], rail_p ^ rail_n};
      h_over <= {h_over[7:0], in_over};
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!nrz_out && !err_out)); // R11

  AST_ZERO_DECODES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (settle > lat && h_zero[lat]) |-> !nrz_out); // R3

  AST_AMI_MARK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (settle > lat && code_sel == 2'b00 && h_mark[lat]) |-> nrz_out); // R3

  AST_BOTH_RAILS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (settle > lat && h_both[lat]) |-> (nrz_out && err_out)); // R9

  AST_RUN_LIMIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (settle > lat && h_over[lat]) |-> err_out); // R8
endmodule

bind bpl_decoder bpl_decoder_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .code_sel (code_sel),
  .rail_p   (rail_p),
  .rail_n   (rail_n),
  .nrz_out  (nrz_out),
  .err_out  (err_out)
);

// File: tb/test_bpl_decoder.sv
`timescale 1ns/1ps
module test_bpl_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic       rail_p = 1'b0;
  logic       rail_n = 1'b0;
  logic       nrz_out, err_out;

  always #4 clk = ~clk;

  bpl_decoder i_bpl_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_sel (code_sel),
    .rail_p   (rail_p),
    .rail_n   (rail_n),
    .nrz_out  (nrz_out),
    .err_out  (err_out)
  );

  localparam int MAXN = 2200;
  int checks = 0;
  int fails  = 0;
  int n;
  int sym  [MAXN];
  bit both [MAXN];
  bit db   [MAXN];
  bit ed   [MAXN];
  bit ee   [MAXN];

  function automatic int lat_of(int md);
    case (md) 0: return 1; 1: return 8; 2: return 6; default: return 4; endcase
  endfunction

  function automatic int zlim_of(int md);
    case (md) 0: return 15; 1: return 8; 2: return 6; default: return 4; endcase
  endfunction

  task automatic chk(string tag, int idx, bit gd, bit ge, bit xd, bit xe);
    checks++;
    if (gd !== xd || ge !== xe) begin
      fails++;
      $display("FAIL %s bit %0d: nrz=%b err=%b, expected nrz=%b err=%b",
               tag, idx, gd, ge, xd, xe);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < MAXN; i++) begin
      sym[i] = 0; both[i] = 0; db[i] = 0; ed[i] = 0; ee[i] = 0;
    end
  endtask

  task automatic put(int i, int s, bit d, bit e);
    sym[i] = s; ed[i] = d; ee[i] = e;
  endtask

  function automatic bit zeros_ahead(int i, int k);
    if (i + k > n) return 0;
    for (int t = 0; t < k; t++) if (db[i+t]) return 0;
    return 1;
  endfunction

  // line encoder model, standard substitution rules
  task automatic encode(int md);
    int last = 0;
    int marks = 0;
    int i = 0;
    while (i < n) begin
      if (md == 1 && last != 0 && zeros_ahead(i, 8)) begin
        sym[i+3] = last; sym[i+4] = -last; sym[i+6] = -last; sym[i+7] = last;
        i += 8;
      end else if (md == 2 && last != 0 && zeros_ahead(i, 6)) begin
        sym[i+1] = last; sym[i+2] = -last; sym[i+4] = -last; sym[i+5] = last;
        i += 6;
      end else if (md == 3 && last != 0 && zeros_ahead(i, 4)) begin
        if (marks % 2 == 1) begin
          sym[i+3] = last;
        end else begin
          last = -last;
          sym[i] = last; sym[i+3] = last;
        end
        marks = 0;
        i += 4;
      end else begin
        if (db[i]) begin
          last = (last == 1) ? -1 : 1;
          sym[i] = last;
          marks++;
        end
        i++;
      end
    end
  endtask

  task automatic fill_zero_run(int md);
    int run = 0;
    for (int i = 0; i < n; i++) begin
      if (sym[i] == 0 && !both[i]) begin
        run++;
        if (run == zlim_of(md) + 1) ee[i] = 1;
      end else run = 0;
    end
  endtask

  task automatic run_scn(int md, bit swp, string tag);
    int L;
    bit p, q;
    L = lat_of(md);
    code_sel = md[1:0];
    rst_n = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", -1, nrz_out, err_out, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int j = 0; j < n + L; j++) begin
      if (j < n) begin
        p = both[j] || (sym[j] == 1);
        q = both[j] || (sym[j] == -1);
      end else begin
        p = 0; q = 0;
      end
      rail_p = swp ? q : p;
      rail_n = swp ? p : q;
      @(negedge clk);
      if (j - L >= 0) chk(tag, j - L, nrz_out, err_out, ed[j-L], ee[j-L]);
    end
  endtask

  task automatic sweep(int md, string tag);
    clear_all();
    n = 2049;
    db[0] = 1;
    for (int w = 0; w < 256; w++)
      for (int b = 0; b < 8; b++) db[1 + w*8 + b] = w[7-b];
    encode(md);
    for (int i = 0; i < n; i++) ed[i] = db[i];
    fill_zero_run(md);
    run_scn(md, 1'b0, tag);
    run_scn(md, 1'b1, "R10 swapped rails");
  endtask

  initial begin
    // full byte sweep per code, both rail orders (R1 latency, R2 select)
    sweep(0, "R1 R2 R3 mark-inversion sweep");
    sweep(1, "R1 R2 R4 8-zero sweep");
    sweep(2, "R1 R2 R5 6-zero sweep");
    sweep(3, "R1 R2 R6 4-zero sweep");

    // R7: repeated polarity in mark-inversion mode
    clear_all(); n = 6;
    put(0, 1, 1, 0); put(2, 1, 1, 1); put(3, -1, 1, 0); put(4, -1, 1, 1);
    run_scn(0, 1'b0, "R7 mark-inversion violation");

    // R7: corrupted 8-zero substitution is not removed
    clear_all(); n = 9;
    put(0, 1, 1, 0); put(4, 1, 1, 1); put(5, -1, 1, 0); put(7, 1, 1, 0); put(8, -1, 1, 0);
    run_scn(1, 1'b0, "R7 corrupted 8-zero pattern");

    // R7: violation in 4-zero mode
    clear_all(); n = 4;
    put(0, 1, 1, 0); put(2, 1, 1, 1); put(3, -1, 1, 0);
    run_scn(3, 1'b0, "R7 4-zero violation");

    // R9: both rails high, polarity kept
    clear_all(); n = 4;
    put(0, 1, 1, 0); both[1] = 1; ed[1] = 1; ee[1] = 1; put(2, -1, 1, 0);
    run_scn(3, 1'b0, "R9 both rails");

    // R8: zero-run limits per mode
    clear_all(); n = 8;
    put(0, 1, 1, 0); ee[5] = 1; put(7, -1, 1, 0);
    run_scn(3, 1'b0, "R8 4-zero run limit");
    clear_all(); n = 19;
    put(0, 1, 1, 0); ee[16] = 1; put(18, -1, 1, 0);
    run_scn(0, 1'b0, "R8 mark-inversion run limit");
    clear_all(); n = 10;
    put(0, 1, 1, 0); ee[7] = 1; put(9, -1, 1, 0);
    run_scn(2, 1'b0, "R8 6-zero run limit");

    // R11: reset forgets the last polarity
    clear_all(); n = 2;
    put(0, 1, 1, 0);
    run_scn(0, 1'b0, "R11 before reset");
    clear_all(); n = 3;
    put(0, 1, 1, 0); put(2, -1, 1, 0);
    run_scn(0, 1'b0, "R11 first mark after reset");

    // R11: no substitution recognised before the first pulse
    clear_all(); n = 8;
    put(3, 1, 1, 0); put(4, -1, 1, 0); put(6, -1, 1, 1); put(7, 1, 1, 0);
    run_scn(1, 1'b0, "R11 pattern before any pulse");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule